// File: doc/BRIEF.md
# Two-Wire Write-Only Slave Decoder

This block is a receive-only slave for a two-wire serial bus. It runs on a fast system clock and oversamples the bus clock and data lines. It recognises START and STOP conditions and compares the first byte after each START against two addresses. The first is a device address whose upper bits are fixed and whose lower three bits come from strap pins. The second is a fixed broadcast address shared by several devices.

For the device address, the block accepts either a one-byte command transfer or a three-byte transfer: a command byte, then a low data byte, then a high data byte. It acknowledges each byte by asserting an active-high enable that pulls the shared data line low. On the rising clock edge of each acknowledge slot it reports what it has just accepted, as a single-cycle pulse with the captured value. A transfer that is cut short by a START or STOP keeps only the fields whose acknowledge slot has completed. The broadcast address takes no further bytes: the bit in the read/write position is returned together with a one-cycle event.

Top module: `smb_wr_slave`

## Requirements
- R1: After reset the data-line enable, every event pulse, the command, data and broadcast-bit outputs are all 0.
- R2: A STOP is the data line rising while the clock line is high, and a START is the data line falling while the clock line is high. Each STOP on the bus produces exactly one `stop_o` pulse, whatever state the block is in, and releases the data-line enable.
- R3: The first byte after a START is acknowledged as a device address only when it equals `0100` followed by `addr_strap_i[2:0]` (MSB first) and then a write bit of 0. Any other byte, except the broadcast address of R9, is not acknowledged, and no later byte is acknowledged until the next START.
- R4: In a full transfer, `cmd_valid_o` pulses with the first byte after the address on `cmd_o`. `data_valid_o` then pulses with `data_o` = {high byte bits [1:0], low byte}. Bits [7:2] of the high byte are discarded.
- R5: During each acknowledge slot the enable `sda_oe_o` is asserted only after the clock line has gone low. It then stays asserted for the whole high phase of the ninth clock and is released after that clock falls.
- R6: Address followed by a command byte and then STOP yields a command pulse and no data pulse.
- R7: A START or STOP after the command acknowledge but before the high-byte acknowledge produces no data pulse. The command pulse already given stands.
- R8: A START or STOP before the command acknowledge produces no command pulse.
- R9: The address byte `1111110` followed by any eighth bit is acknowledged. `quick_valid_o` pulses on the rising clock of that acknowledge slot, with `quick_bit_o` equal to the eighth bit.
- R10: A repeated START at any point restarts address reception, and a following transfer is decoded normally.
- R11: Each event pulse lasts one system clock and occurs only while the data-line enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, sampled |
| sda_i | input | 1 | Bus data line, sampled (wired level) |
| addr_strap_i | input | 3 | Low three bits of the device address |
| sda_oe_o | output | 1 | 1 = pull the data line low (acknowledge) |
| cmd_valid_o | output | 1 | Command byte accepted pulse |
| cmd_o | output | 8 | Last accepted command byte |
| data_valid_o | output | 1 | Data word accepted pulse |
| data_o | output | 10 | Last accepted data word |
| stop_o | output | 1 | STOP condition pulse |
| quick_valid_o | output | 1 | Broadcast address event pulse |
| quick_bit_o | output | 1 | Eighth bit of the last broadcast address |

## Verification
The two functions that overlap in time are driving the acknowledge and reporting a field: each event pulse fires in the same system cycle that the synchronised clock rises inside an acknowledge slot, while the enable is still held. The bench provokes this on every accepted byte. A scoreboard judges the event value and order, and the bench samples the enable in the middle of every acknowledge high phase. The overlap is also checked cycle by cycle by a property that allows a pulse only while the enable is asserted. Interruptions by START and STOP are placed inside command, low and high bytes, so the scoreboard shows which fields survive.

// File: rtl/smb_wr_pkg.sv
package smb_wr_pkg;
    localparam int BYTE_W   = 8;
    localparam int DATA_W   = 10;
    localparam int STRAP_W  = 3;
    localparam int CNT_W    = 4;
    localparam int ACK_SLOT = BYTE_W;
    localparam int ACK_DONE = BYTE_W + 1;

    localparam logic [BYTE_W-STRAP_W-2:0] DEV_TOP    = 4'b0100;
    localparam logic [BYTE_W-2:0]         BCAST_ADDR = 7'b1111110;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_LO,
        PH_HI,
        PH_DROP
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic scl;
        logic sda;
    } bus_ev_t;

    function automatic logic dev_match(input logic [BYTE_W-1:0] b,
                                       input logic [STRAP_W-1:0] strap);
        return b == {DEV_TOP, strap, 1'b0};
    endfunction

    function automatic logic bcast_match(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1:1] == BCAST_ADDR;
    endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
    import smb_wr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;

    genvar g;
    generate
        for (g = 0; g <= STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe[g] <= 1'b1;
                    sda_pipe[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_pipe[g] <= scl_i;
                    sda_pipe[g] <= sda_i;
                end else begin
                    scl_pipe[g] <= scl_pipe[g-1];
                    sda_pipe[g] <= sda_pipe[g-1];
                end
            end
        end
    endgenerate

    logic scl_now, scl_prev, sda_now, sda_prev;
    assign scl_now  = scl_pipe[STAGES-1];
    assign scl_prev = scl_pipe[STAGES];
    assign sda_now  = sda_pipe[STAGES-1];
    assign sda_prev = sda_pipe[STAGES];

    always_comb begin
        ev.scl   = scl_now;
        ev.sda   = sda_now;
        ev.rise  = scl_now & ~scl_prev;
        ev.fall  = ~scl_now & scl_prev;
        ev.start = scl_now & scl_prev & sda_prev & ~sda_now;
        ev.stop  = scl_now & scl_prev & ~sda_prev & sda_now;
    end
endmodule

// File: rtl/smb_bit_shift.sv
module smb_bit_shift
    import smb_wr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              shift,
    input  logic              adv,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] byte_o,
    output logic [CNT_W-1:0]  cnt_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            byte_o <= '0;
            cnt_o  <= '0;
        end else if (clr) begin
            cnt_o  <= '0;
        end else if (shift) begin
            byte_o <= {byte_o[BYTE_W-2:0], bit_in};
            cnt_o  <= cnt_o + 1'b1;
        end else if (adv) begin
            cnt_o  <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/smb_wr_slave.sv
module smb_wr_slave
    import smb_wr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] addr_strap_i,
    output logic               sda_oe_o,
    output logic               cmd_valid_o,
    output logic [BYTE_W-1:0]  cmd_o,
    output logic               data_valid_o,
    output logic [DATA_W-1:0]  data_o,
    output logic               stop_o,
    output logic               quick_valid_o,
    output logic               quick_bit_o
);
    bus_ev_t            ev;
    phase_e             phase;
    logic               is_bcast;
    logic [BYTE_W-1:0]  lo_q;
    logic [BYTE_W-1:0]  rx_byte;
    logic [CNT_W-1:0]   cnt;
    logic               scl_q;
    logic               rx_active, at_slot, at_done;
    logic               sh_clr, sh_shift, sh_adv;

    smb_line_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    assign scl_q     = ev.scl;
    assign rx_active = (phase == PH_ADDR) || (phase == PH_CMD) ||
                       (phase == PH_LO)   || (phase == PH_HI);
    assign at_slot   = (cnt == CNT_W'(ACK_SLOT));
    assign at_done   = (cnt == CNT_W'(ACK_DONE));

    always_comb begin
        sh_clr   = ev.start | ev.stop | (ev.fall & at_done);
        sh_shift = ev.rise & rx_active & (cnt < CNT_W'(ACK_SLOT));
        sh_adv   = ev.rise & rx_active & at_slot & sda_oe_o;
    end

    smb_bit_shift u_shift (
        .clk(clk), .rst(rst), .clr(sh_clr), .shift(sh_shift), .adv(sh_adv),
        .bit_in(ev.sda), .byte_o(rx_byte), .cnt_o(cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase         <= PH_IDLE;
            is_bcast      <= 1'b0;
            lo_q          <= '0;
            sda_oe_o      <= 1'b0;
            cmd_valid_o   <= 1'b0;
            cmd_o         <= '0;
            data_valid_o  <= 1'b0;
            data_o        <= '0;
            stop_o        <= 1'b0;
            quick_valid_o <= 1'b0;
            quick_bit_o   <= 1'b0;
        end else begin
            cmd_valid_o   <= 1'b0;
            data_valid_o  <= 1'b0;
            stop_o        <= 1'b0;
            quick_valid_o <= 1'b0;
            if (ev.start) begin
                phase    <= PH_ADDR;
                sda_oe_o <= 1'b0;
            end else if (ev.stop) begin
                phase    <= PH_IDLE;
                sda_oe_o <= 1'b0;
                stop_o   <= 1'b1;
            end else if (sh_adv) begin
                unique case (phase)
                    PH_ADDR: if (is_bcast) begin
                        quick_valid_o <= 1'b1;
                        quick_bit_o   <= rx_byte[0];
                    end
                    PH_CMD: begin
                        cmd_valid_o <= 1'b1;
                        cmd_o       <= rx_byte;
                    end
                    PH_HI: begin
                        data_valid_o <= 1'b1;
                        data_o       <= {rx_byte[DATA_W-BYTE_W-1:0], lo_q};
                    end
                    default: ;
                endcase
            end else if (ev.fall && rx_active && at_slot && !sda_oe_o) begin
                unique case (phase)
                    PH_ADDR: begin
                        if (bcast_match(rx_byte)) begin
                            sda_oe_o <= 1'b1;
                            is_bcast <= 1'b1;
                        end else if (dev_match(rx_byte, addr_strap_i)) begin
                            sda_oe_o <= 1'b1;
                            is_bcast <= 1'b0;
                        end else begin
                            phase    <= PH_DROP;
                        end
                    end
                    PH_LO: begin
                        sda_oe_o <= 1'b1;
                        lo_q     <= rx_byte;
                    end
                    default: sda_oe_o <= 1'b1;
                endcase
            end else if (ev.fall && at_done) begin
                sda_oe_o <= 1'b0;
                unique case (phase)
                    PH_ADDR: phase <= is_bcast ? PH_DROP : PH_CMD;
                    PH_CMD:  phase <= PH_LO;
                    PH_LO:   phase <= PH_HI;
                    default: phase <= PH_DROP;
                endcase
            end
        end
    end
endmodule

// File: rtl/smb_wr_slave_chk.sv
module smb_wr_slave_chk (
    input logic clk,
    input logic rst,
    input logic scl_q,
    input logic sda_oe,
    input logic cmd_valid,
    input logic data_valid,
    input logic quick_valid,
    input logic stop
);
    // R11
    pulse_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid | data_valid | quick_valid) |-> sda_oe);

    // R5
    oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !$past(scl_q));

    // R11
    cmd_single_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R11
    data_single_chk: assert property (@(posedge clk) disable iff (rst)
        data_valid |=> !data_valid);

    // R9
    quick_single_chk: assert property (@(posedge clk) disable iff (rst)
        quick_valid |=> !quick_valid);

    // R2
    stop_releases_chk: assert property (@(posedge clk) disable iff (rst)
        stop |-> !sda_oe);

    // R2
    stop_single_chk: assert property (@(posedge clk) disable iff (rst)
        stop |=> !stop);
endmodule

bind smb_wr_slave smb_wr_slave_chk u_chk (
    .clk(clk), .rst(rst), .scl_q(scl_q), .sda_oe(sda_oe_o),
    .cmd_valid(cmd_valid_o), .data_valid(data_valid_o),
    .quick_valid(quick_valid_o), .stop(stop_o)
);

// File: tb/smb_wr_slave_bench.sv
`timescale 1ns/1ps
module smb_wr_slave_bench;
    localparam int H = 12;
    localparam int K_CMD = 0, K_DATA = 1, K_QUICK = 2, K_STOP = 3;

    typedef struct { int kind; int val; string req; } exp_t;

    logic clk = 0, rst = 1;
    logic scl = 1, sda_drv = 1;
    logic [2:0] strap = 3'b101;
    logic sda_oe, cmd_valid, data_valid, stop_p, quick_valid, quick_bit;
    logic [7:0] cmd;
    logic [9:0] data;
    logic sda_line;
    int checks = 0, errors = 0;
    bit done = 0;
    exp_t exp_q[$];

    assign sda_line = sda_drv & ~sda_oe;
    always #2.5 clk = ~clk;

    smb_wr_slave u_smb_wr_slave (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
        .addr_strap_i(strap), .sda_oe_o(sda_oe),
        .cmd_valid_o(cmd_valid), .cmd_o(cmd),
        .data_valid_o(data_valid), .data_o(data),
        .stop_o(stop_p), .quick_valid_o(quick_valid), .quick_bit_o(quick_bit)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input int kind, input int val, input string req);
        exp_t e;
        e.kind = kind; e.val = val; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic pop_cmp(input int kind, input int val);
        exp_t e;
        if (exp_q.size() == 0) begin
            chk(0, "unexpected event", kind * 4096 + val, -1);
        end else begin
            e = exp_q.pop_front();
            chk(e.kind == kind && e.val == val, e.req,
                kind * 4096 + val, e.kind * 4096 + e.val);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_valid)   pop_cmp(K_CMD, int'(cmd));
            if (data_valid)  pop_cmp(K_DATA, int'(data));
            if (quick_valid) pop_cmp(K_QUICK, int'(quick_bit));
            if (stop_p)      pop_cmp(K_STOP, 0);
        end
    end

    task automatic bus_start;
        sda_drv = 1; w(H / 2);
        scl = 1; w(H);
        sda_drv = 0; w(H);
        scl = 0; w(H / 2);
    endtask

    task automatic bus_stop(input string req);
        push(K_STOP, 0, req);
        sda_drv = 0; w(H / 2);
        scl = 1; w(H);
        sda_drv = 1; w(2 * H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_drv = b[i]; w(H / 2);
            scl = 1; w(H);
            scl = 0; w(H / 2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit ack, input string req);
        send_bits(b, 8);
        sda_drv = 1; w(H / 2);
        chk(sda_oe == ack, {req, " ack before clock"}, sda_oe, ack);
        scl = 1; w(H / 2);
        chk(sda_oe == ack, {req, " ack in high phase"}, sda_oe, ack);
        w(H / 2);
        chk(sda_oe == ack, {req, " ack held to end of high"}, sda_oe, ack);
        scl = 0; w(H / 2);
        chk(sda_oe == 0, {req, " ack released"}, sda_oe, 0);
    endtask

    task automatic write_word(input logic [7:0] a, input logic [7:0] c,
                              input logic [7:0] lo, input logic [7:0] hi);
        bus_start();
        send_byte(a, 1, "R3");
        push(K_CMD, c, "R4 cmd");
        send_byte(c, 1, "R4");
        send_byte(lo, 1, "R4");
        push(K_DATA, {hi[1:0], lo}, "R4 data");
        send_byte(hi, 1, "R4");
        bus_stop("R2");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        w(5); rst = 0; w(1);
        // R1 reset state
        chk({sda_oe, cmd_valid, data_valid, stop_p, quick_valid, quick_bit} == 0
            && cmd == 0 && data == 0, "R1", {cmd, data}, 0);
        w(10);

        // R4 full transfer, strap 101
        write_word(8'h4A, 8'hA5, 8'h3C, 8'hFE);

        // R6 command only
        bus_start();
        send_byte(8'h4A, 1, "R3");
        push(K_CMD, 8'h07, "R6 cmd");
        send_byte(8'h07, 1, "R6");
        bus_stop("R6 stop");

        // R7 STOP after low byte
        bus_start();
        send_byte(8'h4A, 1, "R3");
        push(K_CMD, 8'h11, "R7 cmd");
        send_byte(8'h11, 1, "R7");
        send_byte(8'h55, 1, "R7");
        bus_stop("R7 stop");

        // R7 / R10 repeated START inside high byte, then full transfer
        bus_start();
        send_byte(8'h4A, 1, "R3");
        push(K_CMD, 8'h22, "R7 cmd");
        send_byte(8'h22, 1, "R7");
        send_byte(8'h99, 1, "R7");
        send_bits(8'hFF, 4);
        write_word(8'h4A, 8'h33, 8'h01, 8'h03);

        // R8 STOP inside command byte
        bus_start();
        send_byte(8'h4A, 1, "R3");
        send_bits(8'hC3, 5);
        bus_stop("R8 stop");

        // R8 / R10 repeated START inside command byte
        bus_start();
        send_byte(8'h4A, 1, "R3");
        send_bits(8'h5A, 3);
        bus_start();
        send_byte(8'h4A, 1, "R10");
        push(K_CMD, 8'h6E, "R10 cmd");
        send_byte(8'h6E, 1, "R10");
        bus_stop("R10 stop");

        // R3 wrong address then bytes ignored
        bus_start();
        send_byte(8'h4C, 0, "R3 wrong addr");
        send_byte(8'h12, 0, "R3 ignored byte");
        send_byte(8'h34, 0, "R3 ignored byte");
        bus_stop("R3 stop");

        // R3 read bit set not acknowledged
        bus_start();
        send_byte(8'h4B, 0, "R3 read bit");
        bus_stop("R3 stop");

        // R9 broadcast with bit 1 and bit 0
        bus_start();
        push(K_QUICK, 1, "R9 bit1");
        send_byte(8'hFD, 1, "R9");
        send_byte(8'h00, 0, "R9 no further byte");
        bus_stop("R9 stop");
        bus_start();
        push(K_QUICK, 0, "R9 bit0");
        send_byte(8'hFC, 1, "R9");
        bus_stop("R9 stop");

        // R3 other strap value
        strap = 3'b000;
        w(4);
        bus_start();
        send_byte(8'h4A, 0, "R3 old strap");
        bus_stop("R3 stop");
        write_word(8'h40, 8'h80, 8'hFF, 8'h01);

        w(20);
        chk(exp_q.size() == 0, "R11 all events seen", exp_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule